// File: doc/BRIEF.md
# Picture Adjustment Register Sequencer

This block sits between a picture-settings request source and the register file of a TV encoder. It keeps five settings: brightness, contrast, colour saturation, hue, and a test-pattern enable. Each request names one setting and carries a new value. The block checks the value against that setting's legal range and answers with an OK or an error. When a new value is accepted and differs from the stored one, the block sends the encoder the indexed register writes that apply it.

Each access to the encoder is one strobe in one cycle. An index strobe selects a register, and a data strobe writes the selected register. The encoder returns the selected register's contents on a read bus. The test-pattern enable uses that read bus to do a read-modify-write. Brightness and contrast together set two 10-bit video levels, a black level and a white level. Each level is clamped, then sent as a high part and a low part to two neighbouring indices.

Top module: `pic_ctl_seq`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0 and no strobe is active. The stored settings are brightness 127, contrast 127, saturation 165, hue 0 and test enable 0, so a request repeating any of these produces no writes.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. `rsp_valid` pulses in the next cycle. `req_ready` stays 0 for exactly as many cycles as the write sequence has steps: 8 for brightness or contrast, 4 for saturation, 2 for hue and 3 for test enable.
- R3: Control IDs and their ranges are 0 brightness 0..268, 1 contrast 0..1023, 2 saturation 0..255, 3 hue 0..255 and 4 test enable 0..1. A value above its range returns `rsp_err`=1, causes no writes and leaves the stored value unchanged.
- R4: Control IDs 5, 6 and 7 return `rsp_err`=1 and cause no strobe.
- R5: A request whose value equals the stored value returns `rsp_err`=0 and causes no strobe.
- R6: Let b be brightness + 243 and c be contrast. The black level is max(b − c, 243). The white level is min(b + c, 1023).
- R7: A level L aimed at index N is written in four steps: index N, then data L>>2, then index N+1, then data L&3. A brightness or contrast change writes the black level to index 0x0E and then the white level to index 0x1E.
- R8: A saturation change writes the value to index 0x20 and then to index 0x22. A hue change writes the value to index 0x25 only.
- R9: A test-enable change selects index 0x05 and captures `enc_rdata` for one cycle. It then writes back the captured byte with bit 1 set (when enabling) or cleared (when disabling). All other bits keep their captured values.
- R10: `enc_idx_we` and `enc_data_we` are never 1 in the same cycle. Strobes occur only while `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_id | input | 3 | Control ID |
| req_value | input | VAL_W | Requested value |
| rsp_valid | output | 1 | One-cycle pulse after a request is taken |
| rsp_err | output | 1 | Status for the request, valid with `rsp_valid` |
| enc_idx_we | output | 1 | Index strobe: `enc_wdata` selects the encoder register |
| enc_data_we | output | 1 | Data strobe: `enc_wdata` is written to the selected register |
| enc_wdata | output | 8 | Index or data byte |
| enc_rdata | input | 8 | Contents of the currently selected encoder register |

## Verification
The checker watches every cycle for these properties:
- the two strobes are never active together;
- no strobe occurs while the block is idle;
- a response follows every accepted request;
- unknown IDs get an error and cause no strobe;
- the data byte after an index of 0x0F or 0x1F never exceeds 3.

Some behaviours only the bench scenarios can show, because they need the encoder's final register contents and the bench's own record of the settings:
- the clamped level arithmetic across a sweep of brightness and contrast;
- the split placement of each level;
- the fan-out of saturation to two indices;
- bit preservation in the read-modify-write;
- values left unchanged after a rejected request.

// File: rtl/pcs_pkg.sv
// Shared constants, types and per-control tables for the picture sequencer.
// Assumes five controls with fixed IDs 0..4; all other IDs are unknown.
package pcs_pkg;

    localparam int N_CTRL = 5;
    localparam int LVL_W  = 10;

    typedef enum logic [2:0] {
        C_BRIGHT   = 3'd0,
        C_CONTRAST = 3'd1,
        C_SAT      = 3'd2,
        C_HUE      = 3'd3,
        C_TEST     = 3'd4
    } ctrl_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_IDX  = 2'd1,
        OP_DATA = 2'd2,
        OP_READ = 2'd3
    } op_e;

    typedef struct packed {
        op_e        kind;
        logic [7:0] byte_v;
    } op_t;

    localparam logic [11:0] LVL_FLOOR = 12'h0F3;
    localparam logic [11:0] LVL_CEIL  = 12'h3FF;

    localparam logic [7:0] IX_BLACK  = 8'h0E;
    localparam logic [7:0] IX_WHITE  = 8'h1E;
    localparam logic [7:0] IX_SAT_A  = 8'h20;
    localparam logic [7:0] IX_SAT_B  = 8'h22;
    localparam logic [7:0] IX_HUE    = 8'h25;
    localparam logic [7:0] IX_TEST   = 8'h05;
    localparam logic [7:0] TEST_MASK = 8'h02;

    // Largest legal value of each control
    function automatic int ctrl_max(input int i);
        case (i)
            0:       return 268;
            1:       return 1023;
            2:       return 255;
            3:       return 255;
            default: return 1;
        endcase
    endfunction

    // Value each control holds after reset
    function automatic int ctrl_reset(input int i);
        case (i)
            0:       return 127;
            1:       return 127;
            2:       return 165;
            default: return 0;
        endcase
    endfunction

    // Number of sequence steps issued for a change of a control
    function automatic int seq_len(input ctrl_e k);
        case (k)
            C_BRIGHT, C_CONTRAST: return 8;
            C_SAT:                return 4;
            C_HUE:                return 2;
            default:              return 3;
        endcase
    endfunction

endpackage

// File: rtl/pcs_store.sv
// Setting store and request validation.
// Holds one LVL_W-bit value per control and classifies the presented
// request as unknown, out of range, unchanged or a change.
// Assumes acc is high only in a cycle where the request is taken.
module pcs_store
    import pcs_pkg::*;
#(
    parameter int VAL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc,
    input  logic [2:0]       id,
    input  logic [VAL_W-1:0] val,
    output logic             is_err,
    output logic             is_change,
    output logic [LVL_W-1:0] cur [N_CTRL]
);

    logic             known;
    logic [LVL_W-1:0] cur_sel;
    int               max_sel;
    logic             same;
    logic             in_range;

    // Select the stored value and legal maximum of the addressed control
    always_comb begin
        cur_sel = '0;
        max_sel = 0;
        known   = 1'b0;
        for (int i = 0; i < N_CTRL; i++) begin
            if (id == 3'(i)) begin
                cur_sel = cur[i];
                max_sel = ctrl_max(i);
                known   = 1'b1;
            end
        end
    end

    // Classify the request
    always_comb begin
        same      = known && (32'(val) == 32'(cur_sel));
        in_range  = 32'(val) <= 32'(max_sel);
        is_err    = !known || (!same && !in_range);
        is_change = known && !same && in_range;
    end

    // One register per control, loaded on an accepted change
    for (genvar g = 0; g < N_CTRL; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                cur[g] <= LVL_W'(ctrl_reset(g));
            else if (acc && is_change && id == 3'(g))
                cur[g] <= val[LVL_W-1:0];
        end
    end

endmodule

// File: rtl/pcs_levels.sv
// Black and white level arithmetic from brightness and contrast.
// Assumes brightness <= 268 and contrast <= 1023, which the store enforces.
module pcs_levels
    import pcs_pkg::*;
(
    input  logic [LVL_W-1:0] bright,
    input  logic [LVL_W-1:0] contrast,
    output logic [LVL_W-1:0] black,
    output logic [LVL_W-1:0] white
);

    logic [11:0] base;
    logic [11:0] lo;
    logic [11:0] hi;

    // Offset brightness, then clamp the difference and the sum
    always_comb begin
        base  = {2'b00, bright} + LVL_FLOOR;
        lo    = base - {2'b00, contrast};
        hi    = base + {2'b00, contrast};
        black = (contrast > bright) ? LVL_FLOOR[LVL_W-1:0] : lo[LVL_W-1:0];
        white = (hi > LVL_CEIL) ? LVL_CEIL[LVL_W-1:0] : hi[LVL_W-1:0];
    end

endmodule

// File: rtl/pcs_seq.sv
// Encoder access sequencer.
// Steps through the write program of the control that changed, one strobe
// or read slot per cycle. Assumes the level and byte inputs stay stable
// while busy, which holds because no request is taken during a sequence.
module pcs_seq
    import pcs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  ctrl_e            start_kind,
    input  logic [LVL_W-1:0] black,
    input  logic [LVL_W-1:0] white,
    input  logic [7:0]       sat_b,
    input  logic [7:0]       hue_b,
    input  logic             test_on,
    input  logic [7:0]       rdata,
    output logic             busy,
    output logic             idx_we,
    output logic             data_we,
    output logic [7:0]       wdata
);

    ctrl_e      kind;
    logic [2:0] step;
    logic [7:0] cap;
    op_t        op;
    logic       last;
    logic [7:0] test_byte;

    // Modified byte for the read-modify-write
    always_comb test_byte = test_on ? (cap | TEST_MASK) : (cap & ~TEST_MASK);

    // Decode the current step of the active program
    always_comb begin
        op = '{kind: OP_NONE, byte_v: 8'h00};
        case (kind)
            C_BRIGHT, C_CONTRAST: begin
                case (step)
                    3'd0: op = '{OP_IDX,  IX_BLACK};
                    3'd1: op = '{OP_DATA, black[LVL_W-1:2]};
                    3'd2: op = '{OP_IDX,  IX_BLACK + 8'd1};
                    3'd3: op = '{OP_DATA, {6'b0, black[1:0]}};
                    3'd4: op = '{OP_IDX,  IX_WHITE};
                    3'd5: op = '{OP_DATA, white[LVL_W-1:2]};
                    3'd6: op = '{OP_IDX,  IX_WHITE + 8'd1};
                    default: op = '{OP_DATA, {6'b0, white[1:0]}};
                endcase
            end
            C_SAT: begin
                case (step)
                    3'd0:    op = '{OP_IDX, IX_SAT_A};
                    3'd2:    op = '{OP_IDX, IX_SAT_B};
                    default: op = '{OP_DATA, sat_b};
                endcase
            end
            C_HUE: begin
                if (step == 3'd0) op = '{OP_IDX, IX_HUE};
                else              op = '{OP_DATA, hue_b};
            end
            default: begin
                case (step)
                    3'd0:    op = '{OP_IDX,  IX_TEST};
                    3'd1:    op = '{OP_READ, 8'h00};
                    default: op = '{OP_DATA, test_byte};
                endcase
            end
        endcase
    end

    // Drive the encoder bus only while a sequence runs
    always_comb begin
        idx_we  = busy && (op.kind == OP_IDX);
        data_we = busy && (op.kind == OP_DATA);
        wdata   = busy ? op.byte_v : 8'h00;
        last    = int'(step) == seq_len(kind) - 1;
    end

    // Sequence state: start, advance, capture on the read slot, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            kind <= C_BRIGHT;
            step <= 3'd0;
            cap  <= 8'h00;
        end else if (start) begin
            busy <= 1'b1;
            kind <= start_kind;
            step <= 3'd0;
        end else if (busy) begin
            if (op.kind == OP_READ) cap <= rdata;
            if (last) busy <= 1'b0;
            else      step <= step + 3'd1;
        end
    end

endmodule

// File: rtl/pic_ctl_seq.sv
// Top of the picture adjustment sequencer.
// Takes one request at a time, answers one cycle later, and runs the
// encoder write program for accepted changes. Assumes the encoder returns
// the selected register on enc_rdata in the cycle after its index strobe.
module pic_ctl_seq
    import pcs_pkg::*;
#(
    parameter int VAL_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [2:0]       req_id,
    input  logic [VAL_W-1:0] req_value,
    output logic             rsp_valid,
    output logic             rsp_err,
    output logic             enc_idx_we,
    output logic             enc_data_we,
    output logic [7:0]       enc_wdata,
    input  logic [7:0]       enc_rdata
);

    logic             accept;
    logic             is_err;
    logic             is_change;
    logic             busy;
    logic [LVL_W-1:0] cur [N_CTRL];
    logic [LVL_W-1:0] black;
    logic [LVL_W-1:0] white;
    logic             unused_hi;

    // Handshake: idle means ready
    always_comb begin
        req_ready = !busy;
        accept    = req_valid && req_ready;
        unused_hi = ^{cur[C_SAT][9:8], cur[C_HUE][9:8], cur[C_TEST][9:1]};
    end

    // Response pulse one cycle after acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
        end else begin
            rsp_valid <= accept;
            rsp_err   <= accept && is_err;
        end
    end

    pcs_store #(.VAL_W(VAL_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (accept),
        .id        (req_id),
        .val       (req_value),
        .is_err    (is_err),
        .is_change (is_change),
        .cur       (cur)
    );

    pcs_levels u_levels (
        .bright   (cur[C_BRIGHT]),
        .contrast (cur[C_CONTRAST]),
        .black    (black),
        .white    (white)
    );

    pcs_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (accept && is_change),
        .start_kind (ctrl_e'(req_id)),
        .black      (black),
        .white      (white),
        .sat_b      (cur[C_SAT][7:0]),
        .hue_b      (cur[C_HUE][7:0]),
        .test_on    (cur[C_TEST][0]),
        .rdata      (enc_rdata),
        .busy       (busy),
        .idx_we     (enc_idx_we),
        .data_we    (enc_data_we),
        .wdata      (enc_wdata)
    );

endmodule

// File: rtl/pic_ctl_seq_chk.sv
// Port-level property checker for pic_ctl_seq, attached by bind.
// Tracks the most recent index byte to judge low-part level writes.
module pic_ctl_seq_chk #(
    parameter int VAL_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [2:0]       req_id,
    input logic [VAL_W-1:0] req_value,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic             enc_idx_we,
    input logic             enc_data_we,
    input logic [7:0]       enc_wdata
);

    logic [7:0] last_idx;

    // Remember the last selected index
    always_ff @(posedge clk) begin
        if (!rst_n)          last_idx <= 8'h00;
        else if (enc_idx_we) last_idx <= enc_wdata;
    end

    // R10
    no_dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(enc_idx_we && enc_data_we));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_idx_we || enc_data_we) |-> !req_ready);

    // R2
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    // R4
    unknown_id_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_id > 3'd4)
            |=> (rsp_err && !enc_idx_we && !enc_data_we));

    // R3
    contrast_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_id == 3'd1 && 32'(req_value) > 32'd1023)
            |=> rsp_err);

    // R7
    low_part_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enc_data_we && (last_idx == 8'h0F || last_idx == 8'h1F))
            |-> enc_wdata <= 8'd3);

endmodule

bind pic_ctl_seq pic_ctl_seq_chk #(.VAL_W(VAL_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_id      (req_id),
    .req_value   (req_value),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .enc_idx_we  (enc_idx_we),
    .enc_data_we (enc_data_we),
    .enc_wdata   (enc_wdata)
);

// File: tb/sim_pic_ctl_seq.sv
module sim_pic_ctl_seq;

    localparam int VAL_W = 12;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [2:0]       req_id = '0;
    logic [VAL_W-1:0] req_value = '0;
    logic             rsp_valid;
    logic             rsp_err;
    logic             enc_idx_we;
    logic             enc_data_we;
    logic [7:0]       enc_wdata;
    logic [7:0]       enc_rdata;

    int checks = 0;
    int fails  = 0;

    // encoder model
    logic [7:0] ereg [64];
    logic [7:0] esel = 8'h00;
    int idx_cnt = 0;
    int dat_cnt = 0;
    int dual_cnt = 0;
    int early_cnt = 0;

    // bench record of the settings
    int sh [5] = '{127, 127, 165, 0, 0};

    always #2 clk = ~clk;

    pic_ctl_seq #(.VAL_W(VAL_W)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_id(req_id), .req_value(req_value), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .enc_idx_we(enc_idx_we), .enc_data_we(enc_data_we),
        .enc_wdata(enc_wdata), .enc_rdata(enc_rdata)
    );

    assign enc_rdata = ereg[esel[5:0]];

    always @(posedge clk) begin
        if (enc_idx_we) begin
            esel <= enc_wdata;
            idx_cnt <= idx_cnt + 1;
        end
        if (enc_data_we) begin
            ereg[esel[5:0]] <= enc_wdata;
            dat_cnt <= dat_cnt + 1;
        end
        if (enc_idx_we && enc_data_we) dual_cnt <= dual_cnt + 1;
        if ((enc_idx_we || enc_data_we) && req_ready) early_cnt <= early_cnt + 1;
    end

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
        end
    endtask

    function automatic int blv(input int b, input int c);
        int t = b + 243 - c;
        return (t < 243) ? 243 : t;
    endfunction

    function automatic int wlv(input int b, input int c);
        int t = b + 243 + c;
        return (t > 1023) ? 1023 : t;
    endfunction

    function automatic int lim(input int id);
        case (id)
            0: return 268;
            1: return 1023;
            2: return 255;
            3: return 255;
            default: return 1;
        endcase
    endfunction

    function automatic int steps(input int id);
        case (id)
            0, 1: return 8;
            2:    return 4;
            3:    return 2;
            default: return 3;
        endcase
    endfunction

    function automatic int strobes(input int id);
        case (id)
            0, 1: return 8;
            2:    return 4;
            default: return 2;
        endcase
    endfunction

    // issue one request and check status, busy length and strobe count
    task automatic req(input int id, input int val, input string rq);
        bit exp_err;
        bit chg;
        int busy_n;
        exp_err = (id > 4) || (val > lim(id) && val != sh[id]);
        chg = !exp_err && (id <= 4) && (val != sh[id]);
        while (!req_ready) @(negedge clk);
        idx_cnt = 0;
        dat_cnt = 0;
        req_valid = 1'b1;
        req_id = 3'(id);
        req_value = VAL_W'(val);
        @(negedge clk);
        req_valid = 1'b0;
        chk(rsp_valid == 1'b1, {rq, " rsp_valid"}, int'(rsp_valid), 1);
        chk(rsp_err == exp_err, {rq, " rsp_err"}, int'(rsp_err), int'(exp_err));
        busy_n = 0;
        while (!req_ready && busy_n < 50) begin
            busy_n++;
            @(negedge clk);
        end
        chk(busy_n == (chg ? steps(id) : 0), {rq, " R2 busy cycles"}, busy_n,
            chg ? steps(id) : 0);
        chk(idx_cnt + dat_cnt == (chg ? strobes(id) : 0), {rq, " strobes"},
            idx_cnt + dat_cnt, chg ? strobes(id) : 0);
        if (chg) sh[id] = val;
    endtask

    task automatic chk_levels(input string rq);
        int bl, wl;
        bl = blv(sh[0], sh[1]);
        wl = wlv(sh[0], sh[1]);
        chk(ereg[8'h0E] == 8'(bl >> 2), {rq, " R6 R7 black hi"}, ereg[8'h0E], bl >> 2);
        chk(ereg[8'h0F] == 8'(bl & 3),  {rq, " R6 R7 black lo"}, ereg[8'h0F], bl & 3);
        chk(ereg[8'h1E] == 8'(wl >> 2), {rq, " R6 R7 white hi"}, ereg[8'h1E], wl >> 2);
        chk(ereg[8'h1F] == 8'(wl & 3),  {rq, " R6 R7 white lo"}, ereg[8'h1F], wl & 3);
    endtask

    initial begin
        #(4 * 150000);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) ereg[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 idle state after reset
        chk(req_ready == 1'b1, "R1 ready", int'(req_ready), 1);
        chk(rsp_valid == 1'b0, "R1 rsp_valid", int'(rsp_valid), 0);
        chk(!enc_idx_we && !enc_data_we, "R1 strobes", int'(enc_idx_we), 0);

        // R1 R5 repeating reset values writes nothing
        req(0, 127, "R1 R5 bright"); req(1, 127, "R1 R5 contrast");
        req(2, 165, "R1 R5 sat");    req(3, 0, "R1 R5 hue");
        req(4, 0, "R1 R5 test");

        // R4 unknown IDs
        for (int id = 5; id < 8; id++) req(id, 1, "R4 unknown");

        // R3 out-of-range values, then confirm storage kept
        req(0, 269, "R3 bright");  req(1, 1024, "R3 contrast");
        req(2, 256, "R3 sat");     req(3, 300, "R3 hue");
        req(4, 2, "R3 test");
        req(0, 127, "R3 bright kept"); req(1, 127, "R3 contrast kept");
        req(2, 165, "R3 sat kept");

        // R6 R7 sweep brightness against contrast
        foreach (sh[k]) if (k < 0) sh[k] = 0;
        begin
            int cs [9] = '{0, 1, 50, 127, 200, 268, 500, 900, 1023};
            foreach (cs[ci]) begin
                req(1, cs[ci], "R6 contrast set");
                for (int b = 0; b <= 268; b += 13) begin
                    req(0, b, "R6 bright set");
                    chk_levels("sweep");
                end
                req(0, 268, "R6 bright max");
                chk_levels("top");
                req(0, cs[ci] > 268 ? 268 : cs[ci], "R6 bright eq");
                chk_levels("equal");
            end
        end

        // R8 saturation full sweep
        for (int s = 0; s < 256; s++) begin
            req(2, s, "R8 sat");
            chk(ereg[8'h20] == 8'(s), "R8 sat A", ereg[8'h20], s);
            chk(ereg[8'h22] == 8'(s), "R8 sat B", ereg[8'h22], s);
        end

        // R8 hue full sweep, saturation registers untouched
        for (int h = 255; h >= 0; h--) begin
            req(3, h, "R8 hue");
            chk(ereg[8'h25] == 8'(h), "R8 hue reg", ereg[8'h25], h);
            chk(ereg[8'h20] == 8'd255 && ereg[8'h22] == 8'd255, "R8 sat kept",
                ereg[8'h20], 255);
        end

        // R9 read-modify-write preserves the other bits
        begin
            int pats [6] = '{8'hF9, 8'h00, 8'hFF, 8'hA4, 8'h5B, 8'h02};
            foreach (pats[pi]) begin
                ereg[8'h05] = 8'(pats[pi]);
                req(4, 1, "R9 test on");
                chk(ereg[8'h05] == 8'(pats[pi] | 2), "R9 set", ereg[8'h05], pats[pi] | 2);
                ereg[8'h05] = 8'(pats[pi] ^ 8'h81);
                req(4, 0, "R9 test off");
                chk(ereg[8'h05] == 8'((pats[pi] ^ 8'h81) & 8'hFD), "R9 clear",
                    ereg[8'h05], (pats[pi] ^ 8'h81) & 8'hFD);
            end
        end

        // R10 strobe discipline over the whole run
        chk(dual_cnt == 0, "R10 dual strobes", dual_cnt, 0);
        chk(early_cnt == 0, "R10 strobes while ready", early_cnt, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule